// File: doc/BRIEF.md
# Dual-CPU Interrupt Mask and Status Registers

This block sits on a simple synchronous register bus in a two-processor system. It keeps one interrupt enable mask for each CPU and one shared interrupt status word. Software changes any of the three registers through a set/clear write. When the top data bit is 1, the written 1-bits are OR-ed into the register. When the top data bit is 0, the written 1-bits are cleared. The top bit is never stored.

Each source may be enabled for at most one CPU. If a mask write leaves a bit enabled in both masks, the write still takes effect and a sticky error flag rises. External source pulses are OR-ed into the status word on every cycle. Each CPU gets a registered interrupt request line that is high when its mask and the status word have a bit in common.

Top module: `irb_dual_cpu_irq`

## Requirements
- R1: The byte offset 0x0F0 selects the CPU0 mask, 0x1F0 selects the CPU1 mask and 0x2F0 selects the status word. A read request puts the selected register on `bus_rdata` at the next rising edge. `bus_rdata` holds that value until the next read.
- R2: A write with data bit 31 = 1 sets every bit that is 1 in data bits 30:0. Other bits keep their value.
- R3: A write with data bit 31 = 0 clears every bit that is 1 in data bits 30:0. Other bits keep their value.
- R4: Bit 31 of every register always reads as 0, even after a set write of all ones.
- R5: After reset, all three registers, `bus_rdata`, `irq_cpu0`, `irq_cpu1` and `mask_err` are 0.
- R6: A mask write that leaves any bit 1 in both masks applies the write and sets `mask_err` at the same edge.
- R7: `mask_err` stays 1 until reset, even after the overlap is removed.
- R8: `irq_cpuN` goes to 1 exactly when (status AND maskN) is nonzero. It is registered, so it changes one edge after the registers change.
- R9: Each 1 on `src_pulse[30:0]` sets the matching status bit at that edge. A status clear write in the same cycle wins for the bits it clears.
- R10: Any other offset, including those at or above 0x500, reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (11) | Byte offset within the window |
| bus_wdata | input | DATA_W (32) | Write data; bit 31 selects set (1) or clear (0) |
| bus_rdata | output | DATA_W (32) | Registered read data |
| src_pulse | input | DATA_W-1 (31) | External pulses that set status bits |
| irq_cpu0 | output | 1 | Interrupt request to CPU0 |
| irq_cpu1 | output | 1 | Interrupt request to CPU1 |
| mask_err | output | 1 | Sticky flag: a source was enabled for both CPUs |

## Verification
The hardest case to reach from the ports is a status clear write and an external pulse on the same bit in the same cycle. The bench drives the pulse and the clear write from one task at the same falling edge, then reads the status word back. The overlap error is reached by enabling a bit for CPU0 and then for CPU1. The bench then removes the overlap to show that the flag stays set, and only a reset clears it.

// File: rtl/irb_pkg.sv
package irb_pkg;
   localparam int unsigned IRB_WINDOW_BYTES = 'h500;
   localparam int unsigned IRB_NCPU         = 2;

   typedef enum logic [1:0] {
      SEL_MASK0  = 2'd0,
      SEL_MASK1  = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_NONE   = 2'd3
   } irb_sel_e;

   function automatic irb_sel_e irb_decode(input logic [15:0] off);
      irb_sel_e s;
      case (off)
         16'h00F0: s = SEL_MASK0;
         16'h01F0: s = SEL_MASK1;
         16'h02F0: s = SEL_STATUS;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/irb_setclr_reg.sv
module irb_setclr_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic [W-2:0] ext_set,
   output logic [W-1:0] q,
   output logic [W-2:0] q_next
);
   localparam int unsigned VW = W - 1;

   logic [VW-1:0] val_q;
   logic [VW-1:0] merged;

   always_comb begin
      merged = val_q | ext_set;
      if (wr_en) begin
         if (wdata[W-1]) q_next = merged | wdata[VW-1:0];
         else            q_next = merged & ~wdata[VW-1:0];
      end else begin
         q_next = merged;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= q_next;
   end

   assign q = {1'b0, val_q};

   AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[W-1]) |=> ((val_q & $past(wdata[VW-1:0])) == $past(wdata[VW-1:0]))); // R2

   AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[W-1]) |=> ((val_q & $past(wdata[VW-1:0])) == '0)); // R3
endmodule

// File: rtl/irb_excl_check.sv
module irb_excl_check #(
   parameter int unsigned VW = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mask_wr,
   input  logic [VW-1:0] nxt0,
   input  logic [VW-1:0] nxt1,
   input  logic [VW-1:0] cur0,
   input  logic [VW-1:0] cur1,
   output logic          err
);
   logic err_q;
   logic clash;

   assign clash = ((nxt0 | nxt1) != (nxt0 ^ nxt1));

   always_ff @(posedge clk) begin
      if (!rst_n)                err_q <= 1'b0;
      else if (mask_wr && clash) err_q <= 1'b1;
   end

   assign err = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R7

   AST_OVERLAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur0 & cur1) != '0) |-> err_q); // R6
endmodule

// File: rtl/irb_irq_gen.sv
module irb_irq_gen #(
   parameter int unsigned VW   = 31,
   parameter int unsigned NCPU = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [VW-1:0]            status,
   input  logic [NCPU-1:0][VW-1:0]  masks,
   output logic [NCPU-1:0]          irq
);
   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      always_ff @(posedge clk) begin
         if (!rst_n) irq[c] <= 1'b0;
         else        irq[c] <= |(status & masks[c]);
      end
   end
endmodule

// File: rtl/irb_dual_cpu_irq.sv
module irb_dual_cpu_irq
   import irb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-2:0] src_pulse,
   output logic              irq_cpu0,
   output logic              irq_cpu1,
   output logic              mask_err
);
   localparam int unsigned VW   = DATA_W - 1;
   localparam int unsigned NREG = 3;

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (ADDR_W < 11 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must cover the 0x500 window and fit 16 bits");
   end

   irb_sel_e sel;
   logic     in_win;
   logic [NREG-1:0]              wr_sel;
   logic [NREG-1:0][DATA_W-1:0]  regs_q;
   logic [NREG-1:0][VW-1:0]      regs_nxt;
   logic [DATA_W-1:0]            rd_mux;
   logic [IRB_NCPU-1:0]          irq_v;
   logic [IRB_NCPU-1:0][VW-1:0]  masks_v;

   assign in_win = (32'(bus_addr) < IRB_WINDOW_BYTES);

   always_comb begin
      sel = SEL_NONE;
      if (in_win) sel = irb_decode(16'(bus_addr));
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [VW-1:0] ext;
      if (r == int'(SEL_STATUS)) begin : g_status
         assign ext = src_pulse;
      end else begin : g_mask
         assign ext = '0;
      end
      assign wr_sel[r] = bus_req && bus_we && (sel == irb_sel_e'(r));
      irb_setclr_reg #(.W(DATA_W)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_sel[r]),
         .wdata   (bus_wdata),
         .ext_set (ext),
         .q       (regs_q[r]),
         .q_next  (regs_nxt[r])
      );
   end

   always_comb begin
      case (sel)
         SEL_MASK0:  rd_mux = regs_q[0];
         SEL_MASK1:  rd_mux = regs_q[1];
         SEL_STATUS: rd_mux = regs_q[2];
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 bus_rdata <= '0;
      else if (bus_req && !bus_we) bus_rdata <= rd_mux;
   end

   irb_excl_check #(.VW(VW)) u_excl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_wr (wr_sel[0] | wr_sel[1]),
      .nxt0    (regs_nxt[0]),
      .nxt1    (regs_nxt[1]),
      .cur0    (regs_q[0][VW-1:0]),
      .cur1    (regs_q[1][VW-1:0]),
      .err     (mask_err)
   );

   assign masks_v[0] = regs_q[0][VW-1:0];
   assign masks_v[1] = regs_q[1][VW-1:0];

   irb_irq_gen #(.VW(VW), .NCPU(IRB_NCPU)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (regs_q[2][VW-1:0]),
      .masks  (masks_v),
      .irq    (irq_v)
   );

   assign irq_cpu0 = irq_v[0];
   assign irq_cpu1 = irq_v[1];

   AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && sel == SEL_NONE) |=> ($stable(regs_q[0]) && $stable(regs_q[1]))); // R10

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> $stable(bus_rdata)); // R1
endmodule

// File: tb/irb_dual_cpu_irq_tb.sv
module irb_dual_cpu_irq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_req, bus_we;
   logic [10:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [30:0] src_pulse;
   logic        irq_cpu0, irq_cpu1, mask_err;

   int chk_cnt  = 0;
   int pass_cnt = 0;

   localparam logic [10:0] A_M0 = 11'h0F0;
   localparam logic [10:0] A_M1 = 11'h1F0;
   localparam logic [10:0] A_ST = 11'h2F0;

   always #5 clk = ~clk;

   irb_dual_cpu_irq dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_pulse(src_pulse), .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1),
      .mask_err(mask_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk_cnt++;
      if (act === exp) pass_cnt++;
      else $display("FAIL %s: actual %h expected %h", tag, act, exp);
   endtask

   task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R5 rdata", bus_rdata, 32'h0);
      check("R5 irq0", {31'h0, irq_cpu0}, 32'h0);
      check("R5 irq1", {31'h0, irq_cpu1}, 32'h0);
      check("R5 err", {31'h0, mask_err}, 32'h0);
      bus_read(A_M0, v); check("R5 mask0", v, 32'h0);
      bus_read(A_M1, v); check("R5 mask1", v, 32'h0);
      bus_read(A_ST, v); check("R5 status", v, 32'h0);
   endtask

   task automatic t_set_clear();
      logic [31:0] v;
      bus_write(A_M0, 32'h8000_00F0);
      bus_read(A_M0, v); check("R2 R1 set mask0", v, 32'h0000_00F0);
      bus_write(A_M0, 32'h8000_0300);
      bus_read(A_M0, v); check("R2 set keeps others", v, 32'h0000_03F0);
      bus_write(A_M0, 32'h0000_0130);
      bus_read(A_M0, v); check("R3 clear mask0", v, 32'h0000_02C0);
      bus_write(A_ST, 32'hFFFF_FFFF);
      bus_read(A_ST, v); check("R4 bit31 zero", v, 32'h7FFF_FFFF);
      bus_write(A_ST, 32'h7FFF_FFFF);
      bus_read(A_ST, v); check("R3 clear status", v, 32'h0);
      bus_write(A_M0, 32'h7FFF_FFFF);
      bus_read(A_M0, v); check("R3 clear all mask0", v, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus_write(A_M0, 32'h8000_0005);
      bus_write(11'h0F4, 32'h0000_0005);
      bus_write(11'h4F0, 32'h0000_0005);
      bus_write(11'h5F0, 32'h0000_0005);
      bus_read(A_M0, v); check("R10 mask0 untouched", v, 32'h0000_0005);
      bus_read(11'h0F4, v); check("R10 read unmapped", v, 32'h0);
      bus_read(11'h6F0, v); check("R10 read outside window", v, 32'h0);
      bus_write(A_M0, 32'h0000_0005);
   endtask

   task automatic t_irq();
      bus_write(A_M0, 32'h8000_0001);
      bus_write(A_M1, 32'h8000_0002);
      bus_write(A_ST, 32'h8000_0001);
      check("R8 irq0 one edge late", {31'h0, irq_cpu0}, 32'h0);
      @(negedge clk);
      check("R8 irq0 on", {31'h0, irq_cpu0}, 32'h1);
      check("R8 irq1 off", {31'h0, irq_cpu1}, 32'h0);
      bus_write(A_ST, 32'h8000_0002);
      @(negedge clk);
      check("R8 irq1 on", {31'h0, irq_cpu1}, 32'h1);
      bus_write(A_ST, 32'h0000_0003);
      @(negedge clk);
      check("R8 irq0 off", {31'h0, irq_cpu0}, 32'h0);
      check("R8 irq1 cleared", {31'h0, irq_cpu1}, 32'h0);
      check("R6 no error yet", {31'h0, mask_err}, 32'h0);
   endtask

   task automatic t_src();
      logic [31:0] v;
      @(negedge clk);
      src_pulse = 31'h0000_0100;
      @(negedge clk);
      src_pulse = '0;
      bus_read(A_ST, v); check("R9 pulse sets status", v, 32'h0000_0100);
      @(negedge clk);
      src_pulse = 31'h0000_0400;
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_ST; bus_wdata = 32'h0000_0500;
      @(negedge clk);
      src_pulse = '0; bus_req = 1'b0; bus_we = 1'b0;
      bus_read(A_ST, v); check("R9 clear wins over pulse", v, 32'h0);
      @(negedge clk);
      src_pulse = 31'h0000_0800;
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_ST; bus_wdata = 32'h8000_0001;
      @(negedge clk);
      src_pulse = '0; bus_req = 1'b0; bus_we = 1'b0;
      bus_read(A_ST, v); check("R9 pulse with set write", v, 32'h0000_0801);
      bus_write(A_ST, 32'h7FFF_FFFF);
   endtask

   task automatic t_collision();
      logic [31:0] v;
      bus_write(A_M1, 32'h8000_0001);
      check("R6 err raised", {31'h0, mask_err}, 32'h1);
      bus_read(A_M1, v); check("R6 write applied", v, 32'h0000_0003);
      bus_write(A_M1, 32'h0000_0001);
      @(negedge clk);
      check("R7 err sticky", {31'h0, mask_err}, 32'h1);
      do_reset();
      check("R7 R5 err cleared by reset", {31'h0, mask_err}, 32'h0);
      bus_read(A_M1, v); check("R5 mask1 after reset", v, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
      bus_addr = '0; bus_wdata = '0; src_pulse = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear();
      t_unmapped();
      t_irq();
      t_src();
      t_collision();
      $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
      $finish;
   end
endmodule